// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Selector

This block chooses which of two interleaved 512-byte buffers, A and B, a streaming endpoint fills. The endpoint moves data between a storage interface and a USB engine. A processor sets the transfer direction and the selected buffer through a small register port. The buffer-select bit changes only when a qualifier bit is set in the same write. Each buffer has a byte counter. The data source's write strobe increments the counter of the selected buffer. Selecting a buffer clears that buffer's counter.

The engine reports each token it receives as IN or OUT. A token whose type does not match the programmed direction latches a sticky error flag. The processor clears the flag by writing a 1 to it. When the auto-alternate input is high, an end-of-fill strobe swaps the buffers and clears the counter of the newly chosen one. The select bit then reads back as the buffer currently being filled.

Top module: `pingpong_bufsel`

## Requirements
- R1: After reset the control register at address 0xB4 reads 0x00, buffer A is selected, the error flag is 0 and both counters read 0.
- R2: A write to the control register at 0xB4 stores bit 7 as the direction (1 = storage toward USB engine, 0 = the reverse). The direction reads back at bit 7.
- R3: Bit 5 of a control write updates the buffer select only when bit 6 of the same write is 1. Bit 6 always reads back 0. Bit 5 reads back the selected buffer (0 = A, 1 = B).
- R4: A qualified control write that selects a buffer clears that buffer's counter. This applies even when the buffer was already selected.
- R5: Each cycle with fill_stb high increments only the counter of the buffer that was selected before that clock edge. The other counter is unchanged.
- R6: A counter saturates at 512 and does not wrap.
- R7: A token with tok_valid high sets the error flag in two cases: tok_in = 0 (OUT) while the direction is 1, or tok_in = 1 (IN) while the direction is 0. Tokens that match the direction leave the flag unchanged.
- R8: The error flag reads at bit 0 of address 0xB5. It stays set until a write to 0xB5 with bit 0 = 1 clears it. Writing 0 to that bit has no effect. A mismatching token in the same cycle as a clear leaves the flag set.
- R9: With auto_en high, fill_end swaps the selected buffer and clears the new buffer's counter. A strobe in that same cycle counts toward the old buffer. With auto_en low, fill_end has no effect.
- R10: A qualified control write in the same cycle as an auto-mode fill_end takes precedence. The written select applies and no swap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| fill_stb | input | 1 | One byte written into the selected buffer |
| fill_end | input | 1 | Current buffer full; swap request in auto mode |
| auto_en | input | 1 | Automatic buffer alternation enable |
| tok_valid | input | 1 | Token received by the USB engine |
| tok_in | input | 1 | Token type: 1 = IN, 0 = OUT |
| active_b | output | 1 | Selected buffer: 1 = B, 0 = A |
| cnt_a | output | CNT_W | Byte count of buffer A |
| cnt_b | output | CNT_W | Byte count of buffer B |
| ep_err | output | 1 | Sticky direction-mismatch error flag |

## Verification
The hardest situations to reach are the same-cycle collisions. These include a qualified select write landing on the same edge as an auto-mode swap, a strobe landing on a swap edge, and a mismatching token landing on an error-clear write. Directed steps drive each of these collisions deliberately. Saturation needs more than 512 consecutive strobes into one buffer, so a long directed burst builds it. A random phase then mixes every input under a behavioural model that is compared on every clock.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;
   typedef enum logic {TOK_OUT = 1'b0, TOK_IN = 1'b1} tok_kind_e;
   localparam int DIR_BIT    = 7;
   localparam int QUAL_BIT   = 6;
   localparam int SEL_BIT    = 5;
   localparam int ERRCLR_BIT = 0;
endpackage

// File: rtl/pbs_byte_cnt.sv
module pbs_byte_cnt #(
   parameter int MAX_COUNT = 512,
   parameter int CW        = $clog2(MAX_COUNT + 1),
   parameter bit SATURATE  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_COUNT);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          at_limit;

   assign at_limit = (cnt_q == LIMIT);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_nxt = cnt_q;
            if (inc && !at_limit) cnt_nxt = cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            cnt_nxt = cnt_q;
            if (inc) cnt_nxt = at_limit ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nxt;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/pbs_err_flag.sv
module pbs_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   input  logic tok_valid,
   input  logic tok_in,
   input  logic clr,
   output logic err
);
   logic mismatch;

   // dir=1 expects IN tokens only, dir=0 expects OUT tokens only
   assign mismatch = tok_valid && (tok_in ^ dir);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err <= 1'b0;
      else if (mismatch) err <= 1'b1;
      else if (clr)      err <= 1'b0;
   end
endmodule

// File: rtl/pbs_ctrl_reg.sv
module pbs_ctrl_reg
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hB4,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'hB5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              fill_end,
   input  logic              auto_en,
   input  logic              err,
   output logic              dir,
   output buf_sel_e          sel,
   output logic [1:0]        clr,
   output logic              stat_clr
);
   logic     ctrl_hit;
   logic     sel_wr;
   logic     swap;
   buf_sel_e sel_nxt;

   assign ctrl_hit = reg_wr && (reg_addr == CTRL_ADDR);
   assign sel_wr   = ctrl_hit && reg_wdata[QUAL_BIT];
   assign swap     = auto_en && fill_end && !sel_wr;
   assign stat_clr = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[ERRCLR_BIT];

   always_comb begin
      sel_nxt = sel;
      if (sel_wr)    sel_nxt = buf_sel_e'(reg_wdata[SEL_BIT]);
      else if (swap) sel_nxt = (sel == BUF_A) ? BUF_B : BUF_A;
   end

   assign clr[0] = (sel_wr || swap) && (sel_nxt == BUF_A);
   assign clr[1] = (sel_wr || swap) && (sel_nxt == BUF_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= 1'b0;
         sel <= BUF_A;
      end else begin
         if (ctrl_hit) dir <= reg_wdata[DIR_BIT];
         sel <= sel_nxt;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CTRL_ADDR) begin
         reg_rdata[DIR_BIT] = dir;
         reg_rdata[SEL_BIT] = sel;
      end else if (reg_addr == STAT_ADDR) begin
         reg_rdata[ERRCLR_BIT] = err;
      end
   end
endmodule

// File: rtl/pingpong_bufsel.sv
module pingpong_bufsel
   import pbs_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hB4,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'hB5,
   parameter int BUF_BYTES = 512,
   parameter bit SATURATE  = 1'b1,
   parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              fill_stb,
   input  logic              fill_end,
   input  logic              auto_en,
   input  logic              tok_valid,
   input  logic              tok_in,
   output logic              active_b,
   output logic [CNT_W-1:0]  cnt_a,
   output logic [CNT_W-1:0]  cnt_b,
   output logic              ep_err
);
   localparam int NBUF = 2;

   generate
      if (DATA_W < DIR_BIT + 1) begin : g_bad_data_w
         $error("DATA_W must hold the control bits");
      end
      if (BUF_BYTES < 2 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_depth
         $error("BUF_BYTES must be a power of two of at least 2");
      end
      if (CNT_W < $clog2(BUF_BYTES + 1)) begin : g_bad_cnt_w
         $error("CNT_W too narrow for a full buffer count");
      end
   endgenerate

   logic            dir;
   buf_sel_e        sel;
   logic [NBUF-1:0] clr;
   logic            stat_clr;
   logic            err;
   logic [CNT_W-1:0] cnt [NBUF];

   pbs_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .fill_end(fill_end), .auto_en(auto_en), .err(err),
      .dir(dir), .sel(sel), .clr(clr), .stat_clr(stat_clr)
   );

   pbs_err_flag u_err (
      .clk(clk), .rst_n(rst_n), .dir(dir),
      .tok_valid(tok_valid), .tok_in(tok_in),
      .clr(stat_clr), .err(err)
   );

   generate
      for (genvar i = 0; i < NBUF; i++) begin : g_cnt
         pbs_byte_cnt #(
            .MAX_COUNT(BUF_BYTES), .CW(CNT_W), .SATURATE(SATURATE)
         ) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .clr(clr[i]),
            .inc(fill_stb && (sel == buf_sel_e'(i))),
            .cnt(cnt[i])
         );
      end
   endgenerate

   assign active_b = (sel == BUF_B);
   assign cnt_a    = cnt[0];
   assign cnt_b    = cnt[1];
   assign ep_err   = err;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hB4,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'hB5,
   parameter int BUF_BYTES = 512,
   parameter int CNT_W     = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              fill_end,
   input logic              auto_en,
   input logic              tok_valid,
   input logic              tok_in,
   input logic              active_b,
   input logic [CNT_W-1:0]  cnt_a,
   input logic [CNT_W-1:0]  cnt_b,
   input logic              ep_err
);
   logic qual_wr, auto_swap, err_clr_wr, dir_seen;

   assign qual_wr    = reg_wr && reg_addr == CTRL_ADDR && reg_wdata[6];
   assign auto_swap  = auto_en && fill_end && !qual_wr;
   assign err_clr_wr = reg_wr && reg_addr == STAT_ADDR && reg_wdata[0];

   // direction as last written, tracked independently from the port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_seen <= 1'b0;
      else if (reg_wr && reg_addr == CTRL_ADDR) dir_seen <= reg_wdata[7];
   end

   // R6
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_a <= CNT_W'(BUF_BYTES) && cnt_b <= CNT_W'(BUF_BYTES));

   // R3
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_wr && !(auto_en && fill_end) |=> $stable(active_b));

   // R4
   sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual_wr |=> active_b == $past(reg_wdata[5]) && (active_b ? cnt_b == '0 : cnt_a == '0));

   // R9
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_swap |=> active_b != $past(active_b) && (active_b ? cnt_b == '0 : cnt_a == '0));

   // R5
   other_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_b && !qual_wr && !(auto_en && fill_end) |=> $stable(cnt_b));

   // R7
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && (tok_in != dir_seen) |=> ep_err);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_err && !err_clr_wr |=> ep_err);
endmodule

bind pingpong_bufsel pbs_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
   .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
) u_pbs_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .fill_end(fill_end), .auto_en(auto_en),
   .tok_valid(tok_valid), .tok_in(tok_in), .active_b(active_b),
   .cnt_a(cnt_a), .cnt_b(cnt_b), .ep_err(ep_err)
);

// File: tb/pingpong_bufsel_test.sv
module pingpong_bufsel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'hB4;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       fill_stb = 1'b0, fill_end = 1'b0, auto_en = 1'b0;
   logic       tok_valid = 1'b0, tok_in = 1'b0;
   logic       active_b, ep_err;
   logic [9:0] cnt_a, cnt_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   int m_dir = 0, m_sel = 0, m_err = 0, m_ca = 0, m_cb = 0;

   always #5 clk = ~clk;

   pingpong_bufsel uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_stb(fill_stb),
      .fill_end(fill_end), .auto_en(auto_en), .tok_valid(tok_valid),
      .tok_in(tok_in), .active_b(active_b), .cnt_a(cnt_a), .cnt_b(cnt_b),
      .ep_err(ep_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int model_rdata();
      if (reg_addr == 8'hB4) return m_dir * 128 + m_sel * 32;
      if (reg_addr == 8'hB5) return m_err;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir = 0; m_sel = 0; m_err = 0; m_ca = 0; m_cb = 0;
      end else begin
         int n_sel, n_ca, n_cb, n_dir, n_err;
         bit qual, clr_a, clr_b;
         n_sel = m_sel; n_ca = m_ca; n_cb = m_cb; n_dir = m_dir; n_err = m_err;
         clr_a = 0; clr_b = 0;
         qual = reg_wr && reg_addr == 8'hB4 && reg_wdata[6];
         if (reg_wr && reg_addr == 8'hB4) n_dir = reg_wdata[7];
         if (qual) n_sel = reg_wdata[5];
         else if (auto_en && fill_end) n_sel = 1 - m_sel;
         if (qual || (auto_en && fill_end)) begin
            if (n_sel == 1) clr_b = 1; else clr_a = 1;
         end
         if (fill_stb) begin
            if (m_sel == 0 && m_ca < 512) n_ca = m_ca + 1;
            if (m_sel == 1 && m_cb < 512) n_cb = m_cb + 1;
         end
         if (clr_a) n_ca = 0;
         if (clr_b) n_cb = 0;
         if (tok_valid && ((m_dir == 1 && !tok_in) || (m_dir == 0 && tok_in))) n_err = 1;
         else if (reg_wr && reg_addr == 8'hB5 && reg_wdata[0]) n_err = 0;
         m_sel = n_sel; m_ca = n_ca; m_cb = n_cb; m_dir = n_dir; m_err = n_err;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3", "active_b", int'(active_b), m_sel);
         chk("R5", "cnt_a", int'(cnt_a), m_ca);
         chk("R5", "cnt_b", int'(cnt_b), m_cb);
         chk("R7", "ep_err", int'(ep_err), m_err);
         chk("R2", "reg_rdata", int'(reg_rdata), model_rdata());
      end
   end

   task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                      input bit stb, input bit fe, input bit tv, input bit ti);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      fill_stb = stb; fill_end = fe; tok_valid = tv; tok_in = ti;
      @(posedge clk);
      #2;
      reg_wr = 0; fill_stb = 0; fill_end = 0; tok_valid = 0;
   endtask

   task automatic idle_rd(input logic [7:0] a);
      cyc(0, a, 8'h00, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1", "ctrl read", int'(reg_rdata), 0);
      chk("R1", "active_b", int'(active_b), 0);
      chk("R1", "cnt_a", int'(cnt_a), 0);
      chk("R1", "cnt_b", int'(cnt_b), 0);
      chk("R1", "ep_err", int'(ep_err), 0);
      rst_n = 1'b1;
      idle_rd(8'hB4);

      // R2 direction write without qualifier
      cyc(1, 8'hB4, 8'h80, 0, 0, 0, 0);
      chk("R2", "ctrl read dir", int'(reg_rdata), 8'h80);
      chk("R3", "sel held", int'(active_b), 0);

      // R5 strobes into A
      repeat (5) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      chk("R5", "cnt_a", int'(cnt_a), 5);
      chk("R5", "cnt_b", int'(cnt_b), 0);

      // R3 qualified select of B, bit 6 reads 0
      cyc(1, 8'hB4, 8'h60, 0, 0, 0, 0);
      chk("R3", "sel B", int'(active_b), 1);
      chk("R3", "ctrl read", int'(reg_rdata), 8'h20);
      repeat (3) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      chk("R5", "cnt_b", int'(cnt_b), 3);
      chk("R5", "cnt_a untouched", int'(cnt_a), 5);

      // R3 unqualified bit 5 ignored
      cyc(1, 8'hB4, 8'h00, 0, 0, 0, 0);
      chk("R3", "sel unqualified", int'(active_b), 1);
      chk("R3", "cnt_b kept", int'(cnt_b), 3);

      // R4 reselect clears
      cyc(1, 8'hB4, 8'h60, 0, 0, 0, 0);
      chk("R4", "cnt_b cleared", int'(cnt_b), 0);
      chk("R4", "cnt_a kept", int'(cnt_a), 5);
      cyc(1, 8'hB4, 8'h40, 0, 0, 0, 0);
      chk("R4", "cnt_a cleared", int'(cnt_a), 0);
      chk("R4", "sel A", int'(active_b), 0);

      // R7 / R8 token errors, dir = 0
      cyc(0, 8'hB5, 8'h00, 0, 0, 1, 1);
      chk("R7", "IN with dir0", int'(ep_err), 1);
      cyc(1, 8'hB5, 8'h00, 0, 0, 0, 0);
      chk("R8", "write 0 no effect", int'(reg_rdata), 1);
      cyc(1, 8'hB5, 8'h01, 0, 0, 0, 0);
      chk("R8", "write 1 clears", int'(ep_err), 0);
      cyc(0, 8'hB5, 8'h00, 0, 0, 1, 0);
      chk("R7", "OUT with dir0", int'(ep_err), 0);
      cyc(1, 8'hB4, 8'h80, 0, 0, 0, 0);
      cyc(0, 8'hB5, 8'h00, 0, 0, 1, 1);
      chk("R7", "IN with dir1", int'(ep_err), 0);
      cyc(0, 8'hB5, 8'h00, 0, 0, 1, 0);
      chk("R7", "OUT with dir1", int'(ep_err), 1);
      cyc(1, 8'hB5, 8'h01, 0, 0, 1, 0);
      chk("R8", "set beats clear", int'(ep_err), 1);
      cyc(1, 8'hB5, 8'h01, 0, 0, 0, 0);
      chk("R8", "cleared", int'(ep_err), 0);

      // R6 saturation
      cyc(1, 8'hB4, 8'hC0, 0, 0, 0, 0);
      repeat (511) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      chk("R6", "cnt_a 511", int'(cnt_a), 511);
      repeat (9) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      chk("R6", "cnt_a saturated", int'(cnt_a), 512);

      // R9 auto off: fill_end ignored
      cyc(0, 8'hB4, 8'h00, 0, 1, 0, 0);
      chk("R9", "no swap auto off", int'(active_b), 0);
      chk("R9", "cnt_a kept", int'(cnt_a), 512);

      // R9 auto on
      auto_en = 1'b1;
      cyc(0, 8'hB4, 8'h00, 0, 1, 0, 0);
      chk("R9", "swap to B", int'(active_b), 1);
      chk("R9", "ctrl read", int'(reg_rdata), 8'hA0);
      chk("R9", "cnt_b cleared", int'(cnt_b), 0);
      repeat (4) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      cyc(0, 8'hB4, 8'h00, 1, 1, 0, 0);
      chk("R9", "swap to A", int'(active_b), 0);
      chk("R9", "old buffer got strobe", int'(cnt_b), 5);
      chk("R9", "cnt_a cleared", int'(cnt_a), 0);

      // R10 register write beats swap
      repeat (2) cyc(0, 8'hB4, 8'h00, 1, 0, 0, 0);
      cyc(1, 8'hB4, 8'hC0, 0, 1, 0, 0);
      chk("R10", "write keeps A", int'(active_b), 0);
      chk("R10", "cnt_a cleared", int'(cnt_a), 0);
      cyc(1, 8'hB4, 8'hE0, 0, 1, 0, 0);
      chk("R10", "write selects B", int'(active_b), 1);
      chk("R10", "cnt_b kept clear", int'(cnt_b), 0);

      // random mix against the model
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a, d;
         bit wr;
         wr = ($urandom_range(0, 15) == 0);
         a  = ($urandom_range(0, 1) == 0) ? 8'hB4 : 8'hB5;
         d  = 8'($urandom);
         if ($urandom_range(0, 63) == 0) auto_en = ~auto_en;
         cyc(wr, a, d, $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
             $urandom_range(0, 20) == 0, 1'($urandom));
      end

      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule